// File: doc/BRIEF.md
# Byte-Triggered Diagnostic Memory Window

This block is a slave-side bridge. It lets a host reach any word of a 32-bit internal memory space through a window of four word registers: a read pointer, a write pointer, a data register and a status word. The host can update any register one byte at a time or as a whole word, using byte enables. The block turns certain register writes into single word requests on a simple internal memory port. That port has a request held until acknowledge, a write flag, an address, write data and read data.

An access is triggered only when byte lane 0 of a pointer register is written. The host can therefore stage, repeat or rewrite the upper address bytes at no cost, and then fire the access with the low byte.
- A read pointer trigger fetches a word into the data register.
- A write pointer trigger commits the data register to memory, so the data is loaded before the trigger.

A full-word write to a pointer acts as if the upper bytes were written first and byte 0 last. Longer host transfers are built from repeated single-word accesses, with the address stepping by 4.

Top module: `diag_window`

## Requirements
- R1: A host write to word index 0 (read pointer) or 1 (write pointer) with byte enable 0 clear updates only the enabled bytes of that pointer and starts no internal request.
- R2: A host write with byte enable 0 set, to either pointer, while idle starts exactly one request. `mem_req` rises on the next cycle, holds with a stable address until the cycle `mem_ack` is high, and is low on the cycle after.
- R3: A read pointer trigger issues a request with `mem_we` low. At the acknowledge, the returned word is loaded into the data register (word index 2).
- R4: A write pointer trigger issues a request with `mem_we` high, carrying the data register value captured at the trigger. The addressed word then holds that value.
- R5: A full four-byte write to a pointer stores all four bytes and starts exactly one request, which uses the complete new address.
- R6: `mem_addr` bits [1:0] are always zero during a request. The stored pointer still reads back the host's bits [1:0] unchanged.
- R7: A byte-0 trigger that arrives while a request is pending is ignored. This includes a trigger in the acknowledge cycle. It still updates the pointer bytes, and it sets a sticky overrun flag that only reset clears.
- R8: A read of the data register while a request is pending returns the last value loaded into it.
- R9: A synchronous active-high reset clears both pointers, the data register, busy and overrun.
- R10: Word index 3 reads as status: bit 0 is busy and bit 1 is overrun, with all other bits zero.
- R11: Consecutive single-word writes, followed by reads at addresses stepping by 4, return each word independently.
- R12: A host write to the data register while a read is pending is overwritten by the fetched word at the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 2 | Register word index: 0 read pointer, 1 write pointer, 2 data, 3 status |
| host_be | input | 4 | Byte enables of the host write |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Selected register value |
| busy | output | 1 | Internal request pending |
| overrun | output | 1 | Sticky flag for an ignored trigger |
| mem_req | output | 1 | Internal request, held until acknowledge |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word-aligned internal address |
| mem_wdata | output | 32 | Internal write data |
| mem_ack | input | 1 | Internal acknowledge, one cycle |
| mem_rdata | input | 32 | Internal read data, valid with acknowledge |

## Verification
A new byte-0 trigger and the internal acknowledge of the pending request can fall in the same cycle. A host data-register write can also coincide with the completion of a read.
- To provoke the first case, the memory model's acknowledge latency is set to zero. The second trigger is then driven on exactly the cycle where `mem_ack` is seen high.
- The first case is judged by three things. Only one request must be counted. Overrun must be set. The fetched word must still be the one for the first address.
- The second case is provoked by writing junk to the data register during a long-latency read. It is judged by the data register afterwards holding the fetched word.

// File: rtl/diag_window.sv
module diag_window #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_we,
  input  logic [1:0]    host_sel,
  input  logic [3:0]    host_be,
  input  logic [31:0]   host_wdata,
  output logic [31:0]   host_rdata,
  output logic          busy,
  output logic          overrun,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata
);

  localparam logic [1:0] SEL_RPTR = 2'd0;
  localparam logic [1:0] SEL_WPTR = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;

  logic [31:0]   rptr_q, wptr_q, data_q;
  logic [AW-1:0] addr_q;
  logic [31:0]   wbuf_q;
  logic          busy_q, wr_q, ovr_q;

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                        input logic [3:0] be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++)
      r[8*b +: 8] = be[b] ? nw[8*b +: 8] : old[8*b +: 8];
    return r;
  endfunction

  wire         wr_rptr = host_we && host_sel == SEL_RPTR;
  wire         wr_wptr = host_we && host_sel == SEL_WPTR;
  wire         wr_data = host_we && host_sel == SEL_DATA;
  wire         trig    = (wr_rptr || wr_wptr) && host_be[0];
  wire         start   = trig && !busy_q;
  wire         done    = busy_q && mem_ack;
  wire [31:0]  rptr_n  = merge(rptr_q, host_wdata, host_be);
  wire [31:0]  wptr_n  = merge(wptr_q, host_wdata, host_be);

  always_ff @(posedge clk) begin
    if (rst) begin
      rptr_q <= '0;
      wptr_q <= '0;
      data_q <= '0;
      addr_q <= '0;
      wbuf_q <= '0;
      busy_q <= 1'b0;
      wr_q   <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (wr_rptr) rptr_q <= rptr_n;
      if (wr_wptr) wptr_q <= wptr_n;
      if (done && !wr_q)  data_q <= mem_rdata;
      else if (wr_data)   data_q <= merge(data_q, host_wdata, host_be);
      if (trig && busy_q) ovr_q <= 1'b1;
      if (start) begin
        busy_q <= 1'b1;
        wr_q   <= wr_wptr;
        wbuf_q <= data_q;
        addr_q <= {(wr_wptr ? wptr_n[AW-1:2] : rptr_n[AW-1:2]), 2'b00};
      end else if (done) begin
        busy_q <= 1'b0;
      end
    end
  end

  always_comb begin
    case (host_sel)
      SEL_RPTR: host_rdata = rptr_q;
      SEL_WPTR: host_rdata = wptr_q;
      SEL_DATA: host_rdata = data_q;
      default:  host_rdata = {30'd0, ovr_q, busy_q};
    endcase
  end

  assign busy      = busy_q;
  assign overrun   = ovr_q;
  assign mem_req   = busy_q;
  assign mem_we    = wr_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wbuf_q;

endmodule

module diag_window_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          host_we,
  input logic [1:0]    host_sel,
  input logic [3:0]    host_be,
  input logic          busy,
  input logic          overrun,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ack
);

  wire ptr_wr = host_we && !host_sel[1];

  assert_upper_no_start_R1: assert property (@(posedge clk) disable iff (rst)
    !mem_req && ptr_wr && !host_be[0] |=> !mem_req);

  assert_trigger_starts_R2: assert property (@(posedge clk) disable iff (rst)
    !mem_req && ptr_wr && host_be[0] |=> mem_req);

  assert_req_holds_R2: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  assert_req_drops_R2: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_ack |=> !mem_req);

  assert_addr_aligned_R6: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> mem_addr[1:0] == 2'b00);

  assert_busy_trigger_overrun_R7: assert property (@(posedge clk) disable iff (rst)
    mem_req && ptr_wr && host_be[0] |=> overrun);

  assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);

  assert_status_busy_R10: assert property (@(posedge clk) disable iff (rst)
    busy == mem_req);

endmodule

bind diag_window diag_window_chk #(.AW(AW)) u_chk (.*);

// File: tb/test_diag_window.sv
`timescale 1ns/1ps
module test_diag_window;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_we = 1'b0;
  logic [1:0]  host_sel = 2'd0;
  logic [3:0]  host_be = 4'd0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        busy, overrun, mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  always #10 clk = ~clk;

  diag_window i_diag_window (
    .clk(clk), .rst(rst), .host_we(host_we), .host_sel(host_sel), .host_be(host_be),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .busy(busy), .overrun(overrun),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int vecs = 0, errs = 0, acc_cnt = 0, cyc = 0, dly = 0, cnt = 0;
  logic [31:0] mem [64];
  logic [31:0] ref_mem [64];
  logic [31:0] last_addr = '0;
  logic        req_d = 1'b0;

  function automatic logic [31:0] init_word(input int i);
    return (32'h0101_0101 * i) ^ 32'hA500_0000;
  endfunction

  initial begin
    for (int i = 0; i < 64; i++) begin
      mem[i] = init_word(i);
      ref_mem[i] = init_word(i);
    end
    mem_ack = 1'b0;
    mem_rdata = '0;
  end

  always @(posedge clk) begin
    if (mem_req && !mem_ack) begin
      if (cnt >= dly) begin
        mem_ack <= 1'b1;
        cnt <= 0;
        if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
        else        mem_rdata <= mem[mem_addr[7:2]];
      end else cnt <= cnt + 1;
    end else mem_ack <= 1'b0;
    if (mem_req && !req_d) begin
      acc_cnt <= acc_cnt + 1;
      last_addr <= mem_addr;
    end
    req_d <= mem_req;
  end

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      vecs++; errs++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
      finish_run();
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hwr_now(input logic [1:0] s, input logic [3:0] be, input logic [31:0] d);
    host_we = 1'b1; host_sel = s; host_be = be; host_wdata = d;
    @(posedge clk); #1;
    host_we = 1'b0; host_be = 4'd0;
  endtask

  task automatic hwr(input logic [1:0] s, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    hwr_now(s, be, d);
  endtask

  task automatic hrd(input logic [1:0] s, output logic [31:0] v);
    @(negedge clk);
    host_sel = s; #1;
    v = host_rdata;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic wr_word(input logic [31:0] a, input logic [31:0] d);
    hwr(2'd2, 4'hF, d);
    hwr(2'd1, 4'hF, a);
    wait_idle();
    ref_mem[a[7:2]] = d;
  endtask

  task automatic rd_word(input logic [31:0] a, output logic [31:0] d);
    hwr(2'd0, 4'hF, a);
    wait_idle();
    hrd(2'd2, d);
  endtask

  logic [31:0] v;
  int base_cnt;

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    hrd(2'd0, v); chk("R9 reset rptr", v, 0);
    hrd(2'd1, v); chk("R9 reset wptr", v, 0);
    hrd(2'd2, v); chk("R9 reset data", v, 0);
    hrd(2'd3, v); chk("R10 reset status", v, 0);
    chk("R9 reset req", {31'd0, mem_req}, 0);

    // R1: upper bytes only
    base_cnt = acc_cnt;
    hwr(2'd0, 4'b1110, 32'h1234_5600);
    hwr(2'd0, 4'b1110, 32'h1234_5600);
    hwr(2'd1, 4'b0010, 32'h0000_AB00);
    repeat (4) @(negedge clk);
    chk("R1 no access", acc_cnt - base_cnt, 0);
    hrd(2'd0, v); chk("R1 rptr bytes", v, 32'h1234_5600);
    hrd(2'd1, v); chk("R1 wptr bytes", v, 32'h0000_AB00);

    // R2/R3/R6: byte-0 trigger read, misaligned low bits
    dly = 2;
    hwr(2'd0, 4'b1110, 32'h0000_0000);
    hwr(2'd0, 4'b0001, 32'h0000_0017);
    chk("R2 req rises", {31'd0, mem_req}, 1);
    hrd(2'd3, v); chk("R10 status busy", v, 1);
    wait_idle();
    chk("R2 one access", acc_cnt - base_cnt, 1);
    chk("R6 aligned addr", last_addr, 32'h14);
    hrd(2'd0, v); chk("R6 rptr keeps low bits", v, 32'h17);
    hrd(2'd2, v); chk("R3 fetched word", v, ref_mem[5]);

    // R4/R5: full word write pointer
    base_cnt = acc_cnt;
    wr_word(32'h0000_0022, 32'hCAFE_F00D);
    chk("R5 one access", acc_cnt - base_cnt, 1);
    chk("R5 full addr", last_addr, 32'h20);
    chk("R4 memory", mem[8], 32'hCAFE_F00D);
    rd_word(32'h20, v); chk("R4 readback", v, 32'hCAFE_F00D);

    // R8/R12: data reads during pending read, host write overridden
    dly = 4;
    hwr(2'd0, 4'hF, 32'h0000_0030);
    hrd(2'd2, v); chk("R8 data during busy", v, 32'hCAFE_F00D);
    hwr(2'd2, 4'hF, 32'hDEAD_BEEF);
    wait_idle();
    hrd(2'd2, v); chk("R12 fetched wins", v, ref_mem[12]);

    // R7: trigger in the acknowledge cycle
    dly = 0;
    base_cnt = acc_cnt;
    hwr(2'd0, 4'hF, 32'h0000_0004);
    @(negedge clk);
    @(negedge clk);
    chk("R7 ack present", {31'd0, mem_ack}, 1);
    hwr_now(2'd1, 4'b0001, 32'h0000_0008);
    wait_idle();
    repeat (3) @(negedge clk);
    chk("R7 collision single access", acc_cnt - base_cnt, 1);
    chk("R7 overrun set", {31'd0, overrun}, 1);
    hrd(2'd1, v); chk("R7 pointer updated", v[7:0], 8'h08);
    hrd(2'd2, v); chk("R7 first result kept", v, ref_mem[1]);
    hrd(2'd3, v); chk("R10 status overrun", v, 2);

    // R7: trigger mid-access
    dly = 3;
    base_cnt = acc_cnt;
    hwr(2'd0, 4'hF, 32'h0000_0010);
    hwr(2'd1, 4'hF, 32'h0000_0040);
    wait_idle();
    chk("R7 busy trigger ignored", acc_cnt - base_cnt, 1);
    chk("R7 no write", mem[16], ref_mem[16]);

    // R11: random multi-word transfer, address stepping by 4
    for (int r = 0; r < 3; r++) begin
      int b;
      logic [31:0] d [8];
      b = 4 * ($urandom % 8);
      for (int k = 0; k < 8; k++) begin
        d[k] = $urandom;
        dly = $urandom % 4;
        wr_word(32'(4 * (b + k)) | 32'($urandom % 4), d[k]);
      end
      for (int k = 0; k < 8; k++) begin
        dly = $urandom % 4;
        rd_word(32'(4 * (b + k)), v);
        chk("R11 multi-word", v, ref_mem[b + k]);
      end
    end

    // R9: reset mid-state
    hwr(2'd0, 4'hF, 32'h5555_AAAA);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    hrd(2'd0, v); chk("R9 rptr cleared", v, 0);
    hrd(2'd3, v); chk("R9 status cleared", v, 0);
    finish_run();
  end
endmodule